// File: doc/BRIEF.md
# Fan Speed Ramp Controller

This block sits between the fan speed setting held in a register and the 8-bit speed value that feeds the fan drive converter. Software writes two registers through a simple write port: a target speed and a ramp control register. While ramping is off, every target write shows up on the speed output on the next clock edge. While ramping is on, an 8-bit current-speed counter moves one LSB at a time toward the target. Each step waits for a programmable number of base ticks.

The ramp control register holds the enable in bit 0 and a 3-bit rate code n in bits [3:1]. The step interval is 2^n base ticks, so it ranges from 1 to 128 ticks. The tick input is a one-cycle strobe from a free-running time base outside the block. The interval count restarts whenever a new target is written. A new target written in the middle of a ramp may lie on the other side of the current count. The counter then turns around and heads for the new value.

An over-temperature override input drives the output to full scale (0xFF) at once. It does not wait for the ramp. The counter keeps its own state underneath the override and goes on stepping. The block has two synchronous, active-high resets that do the same thing.

Top module: `fanramp_ctrl`

## Requirements
- R1: When either reset input is high at a clock edge, the target, the ramp control register and the counter become 0x00, and the speed output reads 0x00 after that edge when the override is low.
- R2: With ramp control bit 0 clear, a write with select 0 (target) makes the speed output equal the written byte from the next clock edge on. Base ticks have no effect.
- R3: A write with select 1 that sets bit 0 does not change the speed output. The counter keeps the current target value until a new target is written, whatever ticks arrive.
- R4: While ramping, the counter changes by exactly one LSB each 2^n base ticks, where n is ramp control bits [3:1]. Interval counting starts at the target write, and a tick in the write cycle itself is not counted. The counter moves up when the target is above the count and down when it is below.
- R5: While ramping, the counter holds once it equals the target, even while ticks keep arriving.
- R6: A target written in the middle of a ramp, on the other side of the current count, reverses the counting direction. The next step goes toward the new target.
- R7: While the override input is high, the speed output is 0xFF in the same cycle, with no ramp. When the override falls, the output shows the counter, which kept stepping underneath.
- R8: A write with select 1 that clears bit 0 makes the counter, and so the output, equal the target from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| aux_rst_i | input | 1 | Second synchronous active-high reset, same effect |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Register select: 0 target speed, 1 ramp control |
| wr_data_i | input | 8 | Write data |
| tick_i | input | 1 | One-cycle base time strobe |
| force_full_i | input | 1 | Over-temperature override, forces full scale |
| speed_o | output | 8 | Speed value to the converter |

## Verification
The hardest situation to reach is a turnaround in the middle of a ramp. Reaching it needs ramping enabled, a target far enough from the count that a ramp is in progress, then a second target on the other side of the current count before the first ramp ends. A directed sequence builds this with the fastest rate code and a tick every cycle. A randomized phase then mixes rate codes, sparse writes, ticks, override pulses and rare resets. A cycle-level reference in the bench predicts each output.

// File: rtl/fanramp_pkg.sv
package fanramp_pkg;

    localparam int SPD_W     = 8;
    localparam int RATE_W    = 8;
    localparam int SHIFT_W   = 3;
    localparam int EN_BIT    = 0;
    localparam int SHIFT_LSB = 1;
    localparam int TICKCNT_W = (1 << SHIFT_W) - 1;

    typedef logic [SPD_W-1:0]     speed_t;
    typedef logic [RATE_W-1:0]    rate_t;
    typedef logic [TICKCNT_W-1:0] tickcnt_t;
    typedef logic [SHIFT_W-1:0]   shift_t;

    typedef enum logic {
        SEL_SPEED = 1'b0,
        SEL_RATE  = 1'b1
    } reg_sel_e;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } dir_e;

    typedef struct packed {
        logic  wr_speed;
        logic  wr_rate;
        rate_t data;
    } wr_cmd_t;

    typedef struct packed {
        speed_t target;
        rate_t  rate;
    } cfg_t;

    function automatic logic ramp_on(input rate_t r);
        return r[EN_BIT];
    endfunction

    function automatic shift_t shift_of(input rate_t r);
        return r[SHIFT_LSB +: SHIFT_W];
    endfunction

    // Last tick index of a step interval: 2^n - 1
    function automatic tickcnt_t interval_last(input shift_t n);
        tickcnt_t one;
        one = tickcnt_t'(1);
        return tickcnt_t'((one << n) - one);
    endfunction

    function automatic dir_e dir_of(input speed_t cur, input speed_t tgt);
        if (cur < tgt)      return DIR_UP;
        else if (cur > tgt) return DIR_DOWN;
        else                return DIR_HOLD;
    endfunction

    function automatic speed_t apply_dir(input speed_t cur, input dir_e d);
        case (d)
            DIR_UP:   return cur + speed_t'(1);
            DIR_DOWN: return cur - speed_t'(1);
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/fanramp_regs.sv
module fanramp_regs
    import fanramp_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_i,
    input  wr_cmd_t cmd_i,
    output cfg_t    cfg_q_o,
    output cfg_t    cfg_nxt_o
);
    cfg_t cfg_q;
    cfg_t cfg_nxt;

    always_comb begin
        cfg_nxt = cfg_q;
        if (cmd_i.wr_speed) cfg_nxt.target = speed_t'(cmd_i.data);
        if (cmd_i.wr_rate)  cfg_nxt.rate   = cmd_i.data;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cfg_q <= '0;
        else       cfg_q <= cfg_nxt;
    end

    assign cfg_q_o   = cfg_q;
    assign cfg_nxt_o = cfg_nxt;
endmodule

// File: rtl/fanramp_pacer.sv
module fanramp_pacer
    import fanramp_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   ramp_en_i,
    input  logic   restart_i,
    input  logic   tick_i,
    input  shift_t shift_i,
    output logic   step_o
);
    tickcnt_t tick_cnt_q;
    tickcnt_t last;

    assign last   = interval_last(shift_i);
    // >= so a shorter rate code mid-interval cannot stall the ramp
    assign step_o = ramp_en_i && tick_i && !restart_i && (tick_cnt_q >= last);

    always_ff @(posedge clk_i) begin
        if (rst_i || !ramp_en_i || restart_i) tick_cnt_q <= '0;
        else if (step_o)                      tick_cnt_q <= '0;
        else if (tick_i)                      tick_cnt_q <= tick_cnt_q + tickcnt_t'(1);
    end
endmodule

// File: rtl/fanramp_stepper.sv
module fanramp_stepper
    import fanramp_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   en_nxt_i,
    input  speed_t tgt_nxt_i,
    input  speed_t tgt_q_i,
    input  logic   step_i,
    output speed_t count_o
);
    speed_t count_q;
    speed_t count_nxt;
    dir_e   dir;

    assign dir = dir_of(count_q, tgt_q_i);

    always_comb begin
        if (!en_nxt_i)   count_nxt = tgt_nxt_i;
        else if (step_i) count_nxt = apply_dir(count_q, dir);
        else             count_nxt = count_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) count_q <= '0;
        else       count_q <= count_nxt;
    end

    assign count_o = count_q;
endmodule

// File: rtl/fanramp_ctrl.sv
module fanramp_ctrl
    import fanramp_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             aux_rst_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [SPD_W-1:0] wr_data_i,
    input  logic             tick_i,
    input  logic             force_full_i,
    output logic [SPD_W-1:0] speed_o
);
    logic    rst_any;
    wr_cmd_t cmd;
    cfg_t    cfg_q;
    cfg_t    cfg_nxt;
    logic    en_q;
    logic    step;
    speed_t  count_q;
    logic    unused_rate_hi;

    assign rst_any      = rst_i | aux_rst_i;
    assign cmd.wr_speed = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_SPEED);
    assign cmd.wr_rate  = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_RATE);
    assign cmd.data     = rate_t'(wr_data_i);
    assign en_q         = ramp_on(cfg_q.rate);
    assign unused_rate_hi = ^{cfg_q.rate[RATE_W-1:SHIFT_LSB+SHIFT_W], cfg_nxt.rate};

    fanramp_regs regs_i (
        .clk_i     (clk_i),
        .rst_i     (rst_any),
        .cmd_i     (cmd),
        .cfg_q_o   (cfg_q),
        .cfg_nxt_o (cfg_nxt)
    );

    fanramp_pacer pacer_i (
        .clk_i     (clk_i),
        .rst_i     (rst_any),
        .ramp_en_i (en_q),
        .restart_i (cmd.wr_speed),
        .tick_i    (tick_i),
        .shift_i   (shift_of(cfg_q.rate)),
        .step_o    (step)
    );

    fanramp_stepper stepper_i (
        .clk_i     (clk_i),
        .rst_i     (rst_any),
        .en_nxt_i  (ramp_on(cfg_nxt.rate)),
        .tgt_nxt_i (cfg_nxt.target),
        .tgt_q_i   (cfg_q.target),
        .step_i    (step),
        .count_o   (count_q)
    );

    assign speed_o = force_full_i ? {SPD_W{1'b1}} : count_q;
endmodule

// File: rtl/fanramp_chk.sv
module fanramp_chk
    import fanramp_pkg::*;
(
    input logic   clk_i,
    input logic   rst_i,
    input logic   aux_rst_i,
    input logic   wr_en_i,
    input logic   wr_sel_i,
    input speed_t wr_data_i,
    input logic   tick_i,
    input logic   en_q,
    input speed_t count_q,
    input speed_t target_q
);
    // R4: at most one LSB per clock while ramping and no register write
    a_r4_single_lsb: assert property (@(posedge clk_i) disable iff (rst_i || aux_rst_i)
        (en_q && !wr_en_i) |=> (count_q == $past(count_q)) ||
                               (count_q == $past(count_q) + speed_t'(1)) ||
                               (count_q == $past(count_q) - speed_t'(1)));

    // R4: never moves away from a target that lies above
    a_r4_toward_target: assert property (@(posedge clk_i) disable iff (rst_i || aux_rst_i)
        (en_q && !wr_en_i && count_q < target_q) |=> (count_q >= $past(count_q)));

    // R5: holds once it has arrived
    a_r5_hold_at_target: assert property (@(posedge clk_i) disable iff (rst_i || aux_rst_i)
        (en_q && !wr_en_i && count_q == target_q) |=> $stable(count_q));

    // R2: pass-through of a target write when ramping is off
    a_r2_passthru: assert property (@(posedge clk_i) disable iff (rst_i || aux_rst_i)
        (!en_q && wr_en_i && !wr_sel_i) |=> (count_q == $past(wr_data_i)));

    // R8: disabling loads the target
    a_r8_disable_loads: assert property (@(posedge clk_i) disable iff (rst_i || aux_rst_i)
        (wr_en_i && wr_sel_i && !wr_data_i[EN_BIT]) |=> (count_q == target_q));

    // R3: enabling leaves the count where it is
    a_r3_enable_keeps: assert property (@(posedge clk_i) disable iff (rst_i || aux_rst_i)
        (!en_q && wr_en_i && wr_sel_i && wr_data_i[EN_BIT]) |=> $stable(count_q));
endmodule

bind fanramp_ctrl fanramp_chk chk_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .aux_rst_i (aux_rst_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .tick_i    (tick_i),
    .en_q      (en_q),
    .count_q   (count_q),
    .target_q  (cfg_q.target)
);

// File: tb/fanramp_ctrl_tb_top.sv
module fanramp_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       aux_rst = 1'b0;
    logic       we = 1'b0;
    logic       sel = 1'b0;
    logic [7:0] wd = 8'h00;
    logic       tick = 1'b0;
    logic       force_full = 1'b0;
    logic [7:0] speed;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference state, as it stands after the most recent clock edge
    logic [7:0] m_tgt, m_rate, m_cnt;
    int         m_tk;
    bit         m_was_rst;
    string      tag = "";

    always #2.5 clk = ~clk;

    fanramp_ctrl dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .aux_rst_i    (aux_rst),
        .wr_en_i      (we),
        .wr_sel_i     (sel),
        .wr_data_i    (wd),
        .tick_i       (tick),
        .force_full_i (force_full),
        .speed_o      (speed)
    );

    function automatic logic [7:0] exp_out(input logic f, input logic [7:0] c);
        return f ? 8'hFF : c;
    endfunction

    function automatic string auto_tag();
        if (force_full)            return "R7";
        if (m_was_rst)             return "R1";
        if (!m_rate[0])            return "R2";
        if (m_cnt == m_tgt)        return "R5";
        return "R4";
    endfunction

    // one clock of the reference, for the inputs about to be applied
    task automatic model_edge();
        bit wr_spd, wr_rt, en_now, en_nxt, stp;
        logic [7:0] tgt_nxt;
        int last;
        if (rst || aux_rst) begin
            m_tgt = 0; m_rate = 0; m_cnt = 0; m_tk = 0; m_was_rst = 1;
            return;
        end
        m_was_rst = 0;
        wr_spd  = we && !sel;
        wr_rt   = we && sel;
        en_now  = m_rate[0];
        en_nxt  = wr_rt ? wd[0] : en_now;
        tgt_nxt = wr_spd ? wd : m_tgt;
        last    = (1 << m_rate[3:1]) - 1;
        stp     = en_now && tick && !wr_spd && (m_tk >= last);
        if (!en_nxt)                m_cnt = tgt_nxt;
        else if (stp && m_cnt < m_tgt) m_cnt = m_cnt + 8'd1;
        else if (stp && m_cnt > m_tgt) m_cnt = m_cnt - 8'd1;
        if (!en_now || wr_spd) m_tk = 0;
        else if (tick)         m_tk = stp ? 0 : m_tk + 1;
        m_tgt = tgt_nxt;
        if (wr_rt) m_rate = wd;
    endtask

    task automatic check_now();
        logic [7:0] e;
        string t;
        e = exp_out(force_full, m_cnt);
        t = (tag != "") ? tag : auto_tag();
        n_checks++;
        if (speed !== e) begin
            n_fail++;
            $display("FAIL %s: speed_o=%02h expected %02h at %0t", t, speed, e, $time);
        end
    endtask

    // check at the falling edge, then drive the next inputs
    task automatic cyc(input bit r, input bit ar, input bit w, input bit s,
                       input logic [7:0] d, input bit tk, input bit f);
        @(negedge clk);
        check_now();
        rst = r; aux_rst = ar; we = w; sel = s; wd = d; tick = tk; force_full = f;
        model_edge();
    endtask

    task automatic lit_check(input string t, input logic [7:0] e);
        @(negedge clk);
        n_checks++;
        if (speed !== e) begin
            n_fail++;
            $display("FAIL %s: speed_o=%02h expected %02h at %0t", t, speed, e, $time);
        end
        @(posedge clk);
    endtask

    initial begin
        #(5ns * 60000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_tgt = 0; m_rate = 0; m_cnt = 0; m_tk = 0; m_was_rst = 1;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        model_edge();
        @(posedge clk);
        // R1 reset state
        tag = "R1";
        cyc(0,0,0,0,8'h00,1,0);
        // R2 pass-through, ticks ignored
        tag = "R2";
        cyc(0,0,1,0,8'h40,0,0);
        cyc(0,0,0,0,8'h00,1,0);
        cyc(0,0,0,0,8'h00,1,0);
        // R3 enable keeps count, ticks arrive
        tag = "R3";
        cyc(0,0,1,1,8'h01,1,0);
        for (int i = 0; i < 8; i++) cyc(0,0,0,0,8'h00,1,0);
        // R6 ramp up then reverse
        tag = "R6";
        cyc(0,0,1,0,8'h60,1,0);
        for (int i = 0; i < 10; i++) cyc(0,0,0,0,8'h00,1,0);
        cyc(0,0,1,0,8'h00,1,0);
        for (int i = 0; i < 4; i++) cyc(0,0,0,0,8'h00,1,0);
        cyc(0,0,0,0,8'h00,0,0);
        tag = "";
        lit_check("R6", 8'h46);
        // R4 interval 2^3 = 8 ticks
        tag = "R4";
        cyc(0,0,1,1,8'h07,0,0);
        cyc(0,0,1,0,8'h50,1,0);
        for (int i = 0; i < 24; i++) cyc(0,0,0,0,8'h00,1,0);
        cyc(0,0,0,0,8'h00,0,0);
        tag = "";
        lit_check("R4", 8'h49);
        // R7 override during ramp
        tag = "R7";
        cyc(0,0,0,0,8'h00,1,1);
        for (int i = 0; i < 16; i++) cyc(0,0,0,0,8'h00,1,1);
        tag = "R4";
        cyc(0,0,0,0,8'h00,0,0);
        // R8 disable mid-ramp
        tag = "R8";
        cyc(0,0,1,1,8'h00,0,0);
        cyc(0,0,0,0,8'h00,0,0);
        cyc(0,0,0,0,8'h00,0,0);
        // R1 through the second reset input
        tag = "R1";
        cyc(0,1,0,0,8'h00,0,0);
        cyc(0,0,0,0,8'h00,0,0);
        tag = "";
        // randomized phase
        for (int i = 0; i < 40000; i++) begin
            bit r, ar, w, s, tk, f;
            logic [7:0] d;
            int p;
            p  = $urandom % 10000;
            r  = (p < 4);
            ar = (p >= 4 && p < 8);
            w  = ($urandom % 40) == 0;
            s  = $urandom % 2;
            d  = $urandom;
            if (s) d = {4'h0, d[3:1], ($urandom % 10) < 8};
            tk = $urandom % 2;
            f  = ($urandom % 25) == 0;
            cyc(r, ar, w, s, d, tk, f);
        end
        @(negedge clk);
        check_now();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule